// File: doc/BRIEF.md
# Power Save Mode Controller

This block controls the power state of a display controller. One control register holds three bits: a sleep request, a standby request, and a routing bit. The routing bit decides whether an external power-save input pin adds to the sleep request or to the standby request. The block combines these sources into one operating mode: normal, standby or sleep. From that mode it drives an enable for the internal logic and an enable for the PLL.

Sleep stops the PLL as well as the internal logic. Standby stops only the logic and leaves the PLL running. A counter stands in for the analog PLL and models its lock time. After sleep ends, the counter keeps memory accesses blocked until it expires. After standby ends, accesses resume on the next cycle. Software can read the lock state from a read-only status register. The register port is synchronous and has a single write strobe and a combinational read.

Top module: `pwr_save_ctrl`

## Requirements
- R1: After reset the control register reads 00h, `sleep_o` and `standby_o` are 0, and `pll_locked_o` is 0. `pll_locked_o` rises on the LOCK_CYCLES-th rising edge after reset is released.
- R2: The control register is at address 0. Bit 7 is the routing bit, bit 1 is the sleep bit and bit 0 is the standby bit. All three read back as written. Bits 6..2 always read 0.
- R3: The status register is at address 1. Bit 7 reflects `pll_locked_o` and its other bits read 0. Writes to address 1 change nothing. Any other address reads 00h.
- R4: With the routing bit at 0, the pin is ORed with the sleep bit. A pin change takes effect on `sleep_o` after the second rising edge that samples it.
- R5: With the routing bit at 1, the pin is ORed with the standby bit.
- R6: In sleep, `core_en_o` and `pll_en_o` are both 0.
- R7: In standby, `core_en_o` is 0, `pll_en_o` stays 1, and the PLL lock is held.
- R8: When the sleep and standby conditions are both active, sleep wins: `sleep_o`=1 and `standby_o`=0.
- R9: `pll_locked_o` clears one edge after `pll_en_o` falls. It sets again on the LOCK_CYCLES-th edge after `pll_en_o` returns to 1.
- R10: `mem_ready_o` is 1 only in normal mode with the PLL locked. It returns to 1 in the same cycle in which standby is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_pin_i | input | 1 | External power-save request, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| sleep_o | output | 1 | Sleep mode active |
| standby_o | output | 1 | Standby mode active |
| core_en_o | output | 1 | Enable for internal logic |
| pll_en_o | output | 1 | Enable for the PLL |
| pll_locked_o | output | 1 | Modelled PLL lock status |
| mem_ready_o | output | 1 | Memory access permitted |

## Verification
The most damaging wrong states are a stale lock flag or a lock counter that does not restart after sleep. Either one shows up as `mem_ready_o` rising too early after sleep exit, so the bench checks the cycle just before the expected rise and the cycle of the rise itself. A wrong routing bit or a wrong priority shows up on `sleep_o`/`standby_o` within three cycles of the pin or register change. A lock that is wrongly dropped in standby shows up as `mem_ready_o` staying low in the cycle straight after standby is left.

// File: rtl/pwr_save_pkg.sv
package pwr_save_pkg;
  localparam int DATA_W    = 8;
  localparam int ROUTE_BIT = 7;
  localparam int SLEEP_BIT = 1;
  localparam int STBY_BIT  = 0;
  localparam int LOCK_BIT  = 7;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << ROUTE_BIT) | (DATA_W'(1) << SLEEP_BIT) | (DATA_W'(1) << STBY_BIT);

  typedef enum logic [1:0] {
    PS_NORMAL  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_SLEEP   = 2'd2
  } ps_mode_e;
endpackage

// File: rtl/psm_sync.sv
module psm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/psm_regs.sv
module psm_regs
  import pwr_save_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              locked_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              route_o,
  output logic              sleep_bit_o,
  output logic              stby_bit_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && addr_i == A_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
  end

  always_comb begin
    stat_w = '0;
    stat_w[LOCK_BIT] = locked_i;
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = stat_w;
      default: rdata_o = '0;
    endcase
  end

  assign route_o     = ctrl_q[ROUTE_BIT];
  assign sleep_bit_o = ctrl_q[SLEEP_BIT];
  assign stby_bit_o  = ctrl_q[STBY_BIT];

  // R2: a control write lands in the three defined bits only
  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL) |=>
      (route_o == $past(wdata_i[ROUTE_BIT]) && sleep_bit_o == $past(wdata_i[SLEEP_BIT])
       && stby_bit_o == $past(wdata_i[STBY_BIT])));

  // R3: status writes leave control untouched
  p_stat_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/psm_lock_timer.sv
module psm_lock_timer #(
  parameter int LOCK_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_en_i,
  output logic locked_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!pll_en_i) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (cnt_q == LAST) locked_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked_o = locked_q;

  p_lock_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_i |=> !locked_q);

  p_lock_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> ($past(cnt_q) == LAST && $past(pll_en_i)));
endmodule

// File: rtl/pwr_save_ctrl.sv
module pwr_save_ctrl
  import pwr_save_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int LOCK_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_pin_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              sleep_o,
  output logic              standby_o,
  output logic              core_en_o,
  output logic              pll_en_o,
  output logic              pll_locked_o,
  output logic              mem_ready_o
);
  logic     pin_s;
  logic     route, sleep_bit, stby_bit;
  logic     sleep_req, stby_req;
  logic     locked;
  ps_mode_e mode;

  psm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_pin_i),
    .q_o   (pin_s)
  );

  psm_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(0), .STAT_ADDR(1)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .locked_i   (locked),
    .rdata_o    (reg_rdata_o),
    .route_o    (route),
    .sleep_bit_o(sleep_bit),
    .stby_bit_o (stby_bit)
  );

  // pin steered by the routing bit
  assign sleep_req = sleep_bit | (~route & pin_s);
  assign stby_req  = stby_bit  | ( route & pin_s);

  always_comb begin
    if (sleep_req)     mode = PS_SLEEP;
    else if (stby_req) mode = PS_STANDBY;
    else               mode = PS_NORMAL;
  end

  assign sleep_o   = (mode == PS_SLEEP);
  assign standby_o = (mode == PS_STANDBY);
  assign core_en_o = (mode == PS_NORMAL);
  assign pll_en_o  = (mode != PS_SLEEP);

  psm_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pll_en_i(pll_en_o),
    .locked_o(locked)
  );

  assign pll_locked_o = locked;
  assign mem_ready_o  = core_en_o & locked;

  p_ready_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ready_o |-> (locked && !sleep_req && !stby_req));

  p_stby_holds_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && locked) |=> locked);

  p_sleep_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req && stby_req) |-> (sleep_o && !standby_o && !pll_en_o));

  p_sleep_no_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |=> !locked);
endmodule

// File: tb/sim_pwr_save_ctrl.sv
module sim_pwr_save_ctrl;
  localparam int LOCK = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sleep, stby, core_en, pll_en, locked, ready;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_save_ctrl #(.ADDR_W(2), .LOCK_CYCLES(LOCK), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_pin_i(pin),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sleep_o(sleep), .standby_o(stby), .core_en_o(core_en), .pll_en_o(pll_en),
    .pll_locked_o(locked), .mem_ready_o(ready)
  );

  // {pin, route, sleep_bit, stby_bit, exp_sleep, exp_stby, exp_core, exp_pll}
  localparam logic [7:0] VEC [10] = '{
    8'b0000_0011, 8'b1000_1000, 8'b0010_1000, 8'b0001_0101, 8'b1100_0101,
    8'b0110_1000, 8'b1110_1000, 8'b1001_1000, 8'b0011_1000, 8'b0100_0011
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", rdata, 8'h00);
    chk("R1 modes", {6'b0, sleep, stby}, 8'h00);
    chk("R1 lock", {7'b0, locked}, 8'h00);
    rst_n = 1'b1;
    repeat (LOCK - 1) @(negedge clk);
    chk("R1 lock before", {6'b0, locked, ready}, 8'h00);
    @(negedge clk);
    chk("R1 lock at LOCK", {6'b0, locked, ready}, 8'h03);

    // table walk: routing, priority, enables (R4 R5 R6 R7 R8 R2)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      pin = VEC[i][7];
      wr(2'd0, {VEC[i][6], 5'b0, VEC[i][5:4]});
      repeat (2) @(negedge clk);
      chk("R4/R5/R6/R7/R8 modes", {4'b0, sleep, stby, core_en, pll_en}, {4'b0, VEC[i][3:0]});
      rd(2'd0, r);
      chk("R2 readback", r, {VEC[i][6], 5'b0, VEC[i][5:4]});
    end
    pin = 1'b0;
    wr(2'd0, 8'h00);
    repeat (LOCK + 2) @(negedge clk);
    chk("R10 normal ready", {7'b0, ready}, 8'h01);

    // R4 sync latency
    pin = 1'b1;
    @(negedge clk);
    chk("R4 one edge", {7'b0, sleep}, 8'h00);
    @(negedge clk);
    chk("R4 two edges", {7'b0, sleep}, 8'h01);
    pin = 1'b0;
    repeat (LOCK + 4) @(negedge clk);

    // R9 sleep exit lock wait
    wr(2'd0, 8'h02);
    chk("R6 sleep enables", {6'b0, pll_en, ready}, 8'h00);
    @(negedge clk);
    rd(2'd1, r);
    chk("R9 lock cleared", r, 8'h00);
    wr(2'd0, 8'h00);
    chk("R9 pll back", {6'b0, pll_en, ready}, 8'h02);
    repeat (LOCK - 1) @(negedge clk);
    chk("R9 not yet", {7'b0, ready}, 8'h00);
    @(negedge clk);
    chk("R9 relocked", {7'b0, ready}, 8'h01);
    rd(2'd1, r);
    chk("R3 status lock", r, 8'h80);

    // R7 R10 standby exit without wait
    wr(2'd0, 8'h01);
    repeat (5) @(negedge clk);
    chk("R7 standby lock kept", {5'b0, pll_en, locked, ready}, 8'h06);
    wr(2'd0, 8'h00);
    chk("R10 standby exit immediate", {7'b0, ready}, 8'h01);

    // R3 status write ignored, unmapped reads, R2 reserved bits
    wr(2'd1, 8'hFF);
    rd(2'd1, r);
    chk("R3 status unchanged", r, 8'h80);
    rd(2'd0, r);
    chk("R3 ctrl untouched", r, 8'h00);
    rd(2'd2, r);
    chk("R3 unmapped", r, 8'h00);
    wr(2'd0, 8'hFF);
    rd(2'd0, r);
    chk("R2 reserved zero", r, 8'h83);
    chk("R8 both set", {6'b0, sleep, stby}, 8'h02);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule